// File: doc/BRIEF.md
# Dual Feed Power Input Supervisor

This block watches two DC supply feeds: a primary feed, and a secondary feed that may be left unused. For each feed it receives a stream of voltage magnitude samples and an over-current flag. It runs hysteretic under-voltage and over-voltage alarms for each feed and drives a green or red status light for each feed. It also decides which feed powers the system. The primary feed always wins when it is healthy. When the primary faults, the block moves to the secondary, and it moves back on its own once the fault is gone.

A sticky notification records that a switchover took place, without recording why. A power-fail interrupt is raised when the primary has faulted and the secondary cannot take over. Software writes the four voltage thresholds and the two feed masks through a small register port, and it reads the live alarm state through the same port.

The sample inputs are valid/ready streams. Ready is held high at all times, so the block never applies back-pressure. A sample is taken in any cycle in which its valid is high. The register port and all indications are plain signals.

Top module: `pwr_feed_supervisor`

## Requirements
- R1: Voltage values are unsigned VOLT_W-bit numbers in units of 0.1 V. A feed's under-voltage alarm sets on an accepted sample below the UV-set threshold (default 400). Once set, it clears only on an accepted sample at or above the UV-clear threshold (default 420).
- R2: A feed's over-voltage alarm sets on an accepted sample above the OV-set threshold (default 600). Once set, it clears only on an accepted sample at or below the OV-clear threshold (default 580).
- R3: The thresholds load their defaults at reset. They sit at register addresses 0 (UV-set), 1 (UV-clear), 2 (OV-set) and 3 (OV-clear). A write takes effect from the next cycle, and a read returns the stored value.
- R4: Register address 4 holds the masks: bit 0 masks the primary and bit 1 masks the secondary. A masked feed has no alarms, its over-current count is zero, and both of its lights are off.
- R5: An unmasked feed shows green when its last accepted sample lies within UV-set to OV-set inclusive, and red otherwise. Exactly one of its two lights is on.
- R6: The primary is faulted when it has an under-voltage, over-voltage or qualified over-current alarm. The secondary is healthy when it is unmasked and has none of these alarms. sel_secondary becomes 1 one cycle after the primary is faulted while the secondary is healthy, and becomes 0 one cycle after that condition ends.
- R7: swo_notify sets in the cycle sel_secondary rises and stays set until a write to address 5 with bit 5 = 1. A new switchover in that same cycle keeps it set.
- R8: pfail_irq is 1 one cycle after the primary is faulted while the secondary is not healthy, and 0 otherwise.
- R9: Each over-current flag passes through two synchronizing flops. It becomes qualified after OC_FILT (default 4) consecutive accepted samples that see the synchronized flag high. Any accepted sample that sees it low resets the count.
- R10: Both sample ready outputs are always 1. Voltage inputs present while valid is low have no effect.
- R11: A read of address 5 returns the status word. Bit 0 is primary UV, bit 1 primary OV, bit 2 secondary UV, bit 3 secondary OV, bit 4 sel_secondary, bit 5 swo_notify, bit 6 pfail_irq, bit 7 primary qualified over-current and bit 8 secondary qualified over-current. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_smp_valid | input | 1 | Primary sample valid |
| pri_smp_ready | output | 1 | Primary sample ready (always 1) |
| pri_smp_volts | input | VOLT_W | Primary magnitude, 0.1 V units |
| sec_smp_valid | input | 1 | Secondary sample valid |
| sec_smp_ready | output | 1 | Secondary sample ready (always 1) |
| sec_smp_volts | input | VOLT_W | Secondary magnitude, 0.1 V units |
| pri_ocur_async | input | 1 | Primary over-current flag, asynchronous |
| sec_ocur_async | input | 1 | Secondary over-current flag, asynchronous |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | VOLT_W | Register write data |
| cfg_rdata | output | VOLT_W | Register read data (combinational) |
| pri_led_green | output | 1 | Primary in range |
| pri_led_red | output | 1 | Primary out of range |
| sec_led_green | output | 1 | Secondary in range |
| sec_led_red | output | 1 | Secondary out of range |
| sel_secondary | output | 1 | 1 when the secondary feeds the system |
| swo_notify | output | 1 | Sticky switchover notification |
| pfail_irq | output | 1 | Power-fail interrupt |

## Verification
The bench builds the block with its default parameters. VOLT_W is 12, so readings of a few hundred tenths of a volt sit near every threshold. OC_FILT is 4, so the over-current filter both qualifies and gets reset within a handful of samples. The thresholds load as 400, 420, 600 and 580, so hysteresis bands, exact boundary values and a rewritten threshold can all be driven directly.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [2:0] {
    RA_UV_SET = 3'd0,
    RA_UV_CLR = 3'd1,
    RA_OV_SET = 3'd2,
    RA_OV_CLR = 3'd3,
    RA_MASK   = 3'd4,
    RA_STAT   = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic oc;
    logic ov;
    logic uv;
  } alarm_t;

  localparam int unsigned NUM_FEEDS    = 2;
  localparam int unsigned STAT_CLR_BIT = 5;
endpackage

// File: rtl/pfs_cfg_regs.sv
module pfs_cfg_regs
  import pfs_pkg::*;
#(
  parameter int unsigned VOLT_W     = 12,
  parameter int unsigned UV_SET_DEF = 400,
  parameter int unsigned UV_CLR_DEF = 420,
  parameter int unsigned OV_SET_DEF = 600,
  parameter int unsigned OV_CLR_DEF = 580
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [VOLT_W-1:0] wdata,
  output logic [VOLT_W-1:0] uv_set,
  output logic [VOLT_W-1:0] uv_clr,
  output logic [VOLT_W-1:0] ov_set,
  output logic [VOLT_W-1:0] ov_clr,
  output logic [NUM_FEEDS-1:0] mask,
  output logic              swo_clr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_set <= VOLT_W'(UV_SET_DEF);
      uv_clr <= VOLT_W'(UV_CLR_DEF);
      ov_set <= VOLT_W'(OV_SET_DEF);
      ov_clr <= VOLT_W'(OV_CLR_DEF);
      mask   <= '0;
    end else if (we) begin
      case (reg_addr_e'(addr))
        RA_UV_SET: uv_set <= wdata;
        RA_UV_CLR: uv_clr <= wdata;
        RA_OV_SET: ov_set <= wdata;
        RA_OV_CLR: ov_clr <= wdata;
        RA_MASK:   mask   <= wdata[NUM_FEEDS-1:0];
        default: ;
      endcase
    end
  end

  assign swo_clr = we && (reg_addr_e'(addr) == RA_STAT) && wdata[STAT_CLR_BIT];
endmodule

// File: rtl/pfs_feed_mon.sv
module pfs_feed_mon
  import pfs_pkg::*;
#(
  parameter int unsigned VOLT_W  = 12,
  parameter int unsigned OC_FILT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              masked,
  input  logic              smp_valid,
  input  logic [VOLT_W-1:0] smp_volts,
  input  logic              ocur_async,
  input  logic [VOLT_W-1:0] uv_set,
  input  logic [VOLT_W-1:0] uv_clr,
  input  logic [VOLT_W-1:0] ov_set,
  input  logic [VOLT_W-1:0] ov_clr,
  output alarm_t            alm,
  output logic              led_green,
  output logic              led_red
);
  localparam int unsigned CW = $clog2(OC_FILT + 1);

  logic              oc_s1, oc_s2;
  logic [VOLT_W-1:0] last_v;
  logic              uv_q, ov_q;
  logic [CW-1:0]     oc_cnt;
  logic              in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_s1 <= 1'b0;
      oc_s2 <= 1'b0;
    end else begin
      oc_s1 <= ocur_async;
      oc_s2 <= oc_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         last_v <= '0;
    else if (smp_valid) last_v <= smp_volts;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_q   <= 1'b0;
      ov_q   <= 1'b0;
      oc_cnt <= '0;
    end else if (masked) begin
      uv_q   <= 1'b0;
      ov_q   <= 1'b0;
      oc_cnt <= '0;
    end else if (smp_valid) begin
      uv_q <= uv_q ? (smp_volts < uv_clr) : (smp_volts < uv_set);
      ov_q <= ov_q ? (smp_volts > ov_clr) : (smp_volts > ov_set);
      if (!oc_s2)                      oc_cnt <= '0;
      else if (oc_cnt != CW'(OC_FILT)) oc_cnt <= oc_cnt + CW'(1);
    end
  end

  assign alm.uv = uv_q;
  assign alm.ov = ov_q;
  assign alm.oc = (oc_cnt == CW'(OC_FILT));

  assign in_range  = (last_v >= uv_set) && (last_v <= ov_set);
  assign led_green = !masked && in_range;
  assign led_red   = !masked && !in_range;
endmodule

// File: rtl/pfs_select.sv
module pfs_select
  import pfs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  alarm_t pri_alm,
  input  alarm_t sec_alm,
  input  logic   sec_masked,
  input  logic   swo_clr,
  output logic   sel_sec,
  output logic   swo,
  output logic   pfail
);
  logic pri_fault, sec_ok, sel_nxt;

  assign pri_fault = |pri_alm;
  assign sec_ok    = !sec_masked && !(|sec_alm);
  assign sel_nxt   = pri_fault && sec_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sec <= 1'b0;
      swo     <= 1'b0;
      pfail   <= 1'b0;
    end else begin
      sel_sec <= sel_nxt;
      pfail   <= pri_fault && !sec_ok;
      if (sel_nxt && !sel_sec) swo <= 1'b1;
      else if (swo_clr)        swo <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_feed_supervisor.sv
module pwr_feed_supervisor
  import pfs_pkg::*;
#(
  parameter int unsigned VOLT_W     = 12,
  parameter int unsigned OC_FILT    = 4,
  parameter int unsigned UV_SET_DEF = 400,
  parameter int unsigned UV_CLR_DEF = 420,
  parameter int unsigned OV_SET_DEF = 600,
  parameter int unsigned OV_CLR_DEF = 580
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pri_smp_valid,
  output logic              pri_smp_ready,
  input  logic [VOLT_W-1:0] pri_smp_volts,
  input  logic              sec_smp_valid,
  output logic              sec_smp_ready,
  input  logic [VOLT_W-1:0] sec_smp_volts,
  input  logic              pri_ocur_async,
  input  logic              sec_ocur_async,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [VOLT_W-1:0] cfg_wdata,
  output logic [VOLT_W-1:0] cfg_rdata,
  output logic              pri_led_green,
  output logic              pri_led_red,
  output logic              sec_led_green,
  output logic              sec_led_red,
  output logic              sel_secondary,
  output logic              swo_notify,
  output logic              pfail_irq
);
  logic [VOLT_W-1:0]    uv_set, uv_clr, ov_set, ov_clr;
  logic [NUM_FEEDS-1:0] mask_q;
  logic                 swo_clr;
  logic [NUM_FEEDS-1:0] f_valid, f_ocur, f_green, f_red;
  logic [VOLT_W-1:0]    f_volts [NUM_FEEDS];
  alarm_t               feed_alm [NUM_FEEDS];
  logic [8:0]           status_w;

  assign f_valid    = {sec_smp_valid, pri_smp_valid};
  assign f_ocur     = {sec_ocur_async, pri_ocur_async};
  assign f_volts[0] = pri_smp_volts;
  assign f_volts[1] = sec_smp_volts;

  pfs_cfg_regs #(
    .VOLT_W(VOLT_W), .UV_SET_DEF(UV_SET_DEF), .UV_CLR_DEF(UV_CLR_DEF),
    .OV_SET_DEF(OV_SET_DEF), .OV_CLR_DEF(OV_CLR_DEF)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .uv_set(uv_set), .uv_clr(uv_clr), .ov_set(ov_set), .ov_clr(ov_clr),
    .mask(mask_q), .swo_clr(swo_clr)
  );

  for (genvar g = 0; g < NUM_FEEDS; g++) begin : g_feed
    pfs_feed_mon #(.VOLT_W(VOLT_W), .OC_FILT(OC_FILT)) u_mon (
      .clk(clk), .rst_n(rst_n), .masked(mask_q[g]),
      .smp_valid(f_valid[g]), .smp_volts(f_volts[g]), .ocur_async(f_ocur[g]),
      .uv_set(uv_set), .uv_clr(uv_clr), .ov_set(ov_set), .ov_clr(ov_clr),
      .alm(feed_alm[g]), .led_green(f_green[g]), .led_red(f_red[g])
    );
  end

  pfs_select u_sel (
    .clk(clk), .rst_n(rst_n), .pri_alm(feed_alm[0]), .sec_alm(feed_alm[1]),
    .sec_masked(mask_q[1]), .swo_clr(swo_clr),
    .sel_sec(sel_secondary), .swo(swo_notify), .pfail(pfail_irq)
  );

  assign pri_smp_ready = 1'b1;
  assign sec_smp_ready = 1'b1;
  assign pri_led_green = f_green[0];
  assign pri_led_red   = f_red[0];
  assign sec_led_green = f_green[1];
  assign sec_led_red   = f_red[1];

  assign status_w = {feed_alm[1].oc, feed_alm[0].oc, pfail_irq, swo_notify,
                     sel_secondary, feed_alm[1].ov, feed_alm[1].uv,
                     feed_alm[0].ov, feed_alm[0].uv};

  always_comb begin
    case (reg_addr_e'(cfg_addr))
      RA_UV_SET: cfg_rdata = uv_set;
      RA_UV_CLR: cfg_rdata = uv_clr;
      RA_OV_SET: cfg_rdata = ov_set;
      RA_OV_CLR: cfg_rdata = ov_clr;
      RA_MASK:   cfg_rdata = VOLT_W'(mask_q);
      RA_STAT:   cfg_rdata = VOLT_W'(status_w);
      default:   cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker
  import pfs_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   pri_smp_ready,
  input logic   sec_smp_ready,
  input logic   pri_led_green,
  input logic   pri_led_red,
  input logic   sec_led_green,
  input logic   sec_led_red,
  input logic   sel_secondary,
  input logic   swo_notify,
  input logic   pfail_irq,
  input logic   pri_masked,
  input alarm_t pri_alm
);
  a_r10_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    pri_smp_ready && sec_smp_ready);

  a_r5_pri_led_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(pri_led_green && pri_led_red));

  a_r5_sec_led_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(sec_led_green && sec_led_red));

  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pri_masked |=> (!pri_alm.uv && !pri_alm.ov && !pri_alm.oc));

  a_r7_swo_on_switch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_secondary) |-> swo_notify);

  a_r6_sel_not_pfail: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_secondary && pfail_irq));

  a_r8_pfail_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pfail_irq) |-> $past(|pri_alm));
endmodule

bind pwr_feed_supervisor pfs_checker u_pfs_chk (
  .clk(clk), .rst_n(rst_n),
  .pri_smp_ready(pri_smp_ready), .sec_smp_ready(sec_smp_ready),
  .pri_led_green(pri_led_green), .pri_led_red(pri_led_red),
  .sec_led_green(sec_led_green), .sec_led_red(sec_led_red),
  .sel_secondary(sel_secondary), .swo_notify(swo_notify), .pfail_irq(pfail_irq),
  .pri_masked(mask_q[0]), .pri_alm(feed_alm[0])
);

// File: tb/sim_pwr_feed_supervisor.sv
module sim_pwr_feed_supervisor;
  localparam int VW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pri_smp_valid = 0, sec_smp_valid = 0;
  logic [VW-1:0] pri_smp_volts = '0, sec_smp_volts = '0;
  logic pri_smp_ready, sec_smp_ready;
  logic pri_ocur_async = 0, sec_ocur_async = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_addr = 3'd5;
  logic [VW-1:0] cfg_wdata = '0;
  logic [VW-1:0] cfg_rdata;
  logic pri_led_green, pri_led_red, sec_led_green, sec_led_red;
  logic sel_secondary, swo_notify, pfail_irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwr_feed_supervisor u0 (.*);

  // behavioural reference state
  int m_th[4];
  int m_mask[2];
  int m_last[2];
  int m_uv[2], m_ov[2], m_s1[2], m_s2[2], m_cnt[2];
  int m_sel, m_swo, m_irq;

  function automatic int m_qual(int i);
    return (m_cnt[i] >= 4) ? 1 : 0;
  endfunction

  function automatic int m_pfault();
    return (m_uv[0] | m_ov[0] | m_qual(0));
  endfunction

  function automatic int m_secok();
    return (m_mask[1] == 0 && m_uv[1] == 0 && m_ov[1] == 0 && m_qual(1) == 0) ? 1 : 0;
  endfunction

  function automatic int m_green(int i);
    if (m_mask[i] != 0) return 0;
    return (m_last[i] >= m_th[0] && m_last[i] <= m_th[2]) ? 1 : 0;
  endfunction

  function automatic int m_red(int i);
    if (m_mask[i] != 0) return 0;
    return 1 - m_green(i);
  endfunction

  function automatic int m_rdata(int a);
    if (a < 4) return m_th[a];
    if (a == 4) return m_mask[0] + 2 * m_mask[1];
    if (a == 5) return m_uv[0] + 2*m_ov[0] + 4*m_uv[1] + 8*m_ov[1] + 16*m_sel
                       + 32*m_swo + 64*m_irq + 128*m_qual(0) + 256*m_qual(1);
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin : ref_model
    int pf, sok, seln, clr, vld, vv, oc;
    if (!rst_n) begin
      m_th[0] = 400; m_th[1] = 420; m_th[2] = 600; m_th[3] = 580;
      m_sel = 0; m_swo = 0; m_irq = 0;
      for (int i = 0; i < 2; i++) begin
        m_mask[i] = 0; m_last[i] = 0; m_uv[i] = 0; m_ov[i] = 0;
        m_s1[i] = 0; m_s2[i] = 0; m_cnt[i] = 0;
      end
    end else begin
      pf = m_pfault();
      sok = m_secok();
      seln = pf & sok;
      clr = (cfg_we && cfg_addr == 3'd5 && cfg_wdata[5]) ? 1 : 0;
      m_swo = (seln == 1 && m_sel == 0) ? 1 : ((clr == 1) ? 0 : m_swo);
      m_irq = (pf == 1 && sok == 0) ? 1 : 0;
      m_sel = seln;
      for (int i = 0; i < 2; i++) begin
        vld = (i == 0) ? int'(pri_smp_valid) : int'(sec_smp_valid);
        vv  = (i == 0) ? int'(pri_smp_volts) : int'(sec_smp_volts);
        oc  = (i == 0) ? int'(pri_ocur_async) : int'(sec_ocur_async);
        if (vld == 1) m_last[i] = vv;
        if (m_mask[i] != 0) begin
          m_uv[i] = 0; m_ov[i] = 0; m_cnt[i] = 0;
        end else if (vld == 1) begin
          m_uv[i] = (m_uv[i] != 0) ? ((vv < m_th[1]) ? 1 : 0) : ((vv < m_th[0]) ? 1 : 0);
          m_ov[i] = (m_ov[i] != 0) ? ((vv > m_th[3]) ? 1 : 0) : ((vv > m_th[2]) ? 1 : 0);
          m_cnt[i] = (m_s2[i] != 0) ? ((m_cnt[i] < 4) ? m_cnt[i] + 1 : 4) : 0;
        end
        m_s2[i] = m_s1[i];
        m_s1[i] = oc;
      end
      if (cfg_we) begin
        if (cfg_addr < 3'd4) m_th[cfg_addr] = int'(cfg_wdata);
        else if (cfg_addr == 3'd4) begin
          m_mask[0] = int'(cfg_wdata[0]); m_mask[1] = int'(cfg_wdata[1]);
        end
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // compare with the model on every clock, away from the edges
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #1;
      chk(int'(pri_led_green), m_green(0), "R5 pri green vs model");
      chk(int'(pri_led_red),   m_red(0),   "R5 pri red vs model");
      chk(int'(sec_led_green), m_green(1), "R5 sec green vs model");
      chk(int'(sec_led_red),   m_red(1),   "R5 sec red vs model");
      chk(int'(sel_secondary), m_sel,      "R6 select vs model");
      chk(int'(swo_notify),    m_swo,      "R7 notify vs model");
      chk(int'(pfail_irq),     m_irq,      "R8 irq vs model");
      chk(int'(pri_smp_ready & sec_smp_ready), 1, "R10 ready vs model");
      chk(int'(cfg_rdata), m_rdata(int'(cfg_addr)), "R11 rdata vs model");
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int which, input int v);
    @(negedge clk);
    if (which == 0) begin pri_smp_valid = 1; pri_smp_volts = VW'(v); end
    else            begin sec_smp_valid = 1; sec_smp_volts = VW'(v); end
    @(negedge clk);
    pri_smp_valid = 0;
    sec_smp_valid = 0;
  endtask

  task automatic cfg_wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = VW'(d);
    @(negedge clk);
    cfg_we = 0; cfg_addr = 3'd5; cfg_wdata = '0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(negedge clk);
    cfg_addr = 3'(a);
    @(negedge clk);
    #1;
    chk(int'(cfg_rdata), exp, tag);
    cfg_addr = 3'd5;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (all requirements) actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    step(3);
    rst_n = 1;
    step(1);
    // reset state
    chk(int'(sel_secondary), 0, "R6 reset select");
    chk(int'(swo_notify), 0, "R7 reset notify");
    chk(int'(pfail_irq), 0, "R8 reset irq");
    chk(int'(pri_led_red), 1, "R5 reset red (last sample 0)");
    rd(0, 400, "R3 default UV set");
    rd(1, 420, "R3 default UV clear");
    rd(2, 600, "R3 default OV set");
    rd(3, 580, "R3 default OV clear");
    rd(4, 0,   "R4 default masks");
    rd(7, 0,   "R11 unused address");

    send(0, 480); send(1, 480);
    chk(int'(pri_led_green), 1, "R5 primary in range");
    chk(int'(sec_led_green), 1, "R5 secondary in range");

    // under-voltage hysteresis
    send(0, 399);
    chk(int'(cfg_rdata[0]), 1, "R1 UV raised below set");
    step(1);
    chk(int'(sel_secondary), 1, "R6 switch to secondary on UV");
    chk(int'(swo_notify), 1, "R7 notify on switch");
    send(0, 410);
    step(1);
    chk(int'(sel_secondary), 1, "R1 UV held inside band");
    send(0, 420);
    step(1);
    chk(int'(sel_secondary), 0, "R6 revert to primary");
    chk(int'(swo_notify), 1, "R7 notify sticky after revert");
    cfg_wr(5, 32);
    chk(int'(swo_notify), 0, "R7 notify cleared by write");

    // boundaries and over-voltage hysteresis
    send(0, 400);
    chk(int'(cfg_rdata[0]), 0, "R1 exact set value is no UV");
    send(0, 600);
    chk(int'(cfg_rdata[1]), 0, "R2 exact set value is no OV");
    chk(int'(pri_led_green), 1, "R5 upper bound is green");
    send(0, 601);
    chk(int'(pri_led_red), 1, "R5 above range is red");
    step(1);
    chk(int'(sel_secondary), 1, "R2 OV switches to secondary");
    send(0, 590);
    chk(int'(cfg_rdata[1]), 1, "R2 OV held inside band");
    send(0, 580);
    step(1);
    chk(int'(cfg_rdata[1]), 0, "R2 OV cleared at clear value");
    chk(int'(sel_secondary), 0, "R2 revert after OV clear");

    // over-current qualification
    pri_ocur_async = 1;
    step(3);
    send(0, 500); send(0, 500); send(0, 500);
    step(1);
    chk(int'(sel_secondary), 0, "R9 three samples not qualified");
    send(0, 500);
    chk(int'(cfg_rdata[7]), 1, "R9 four samples qualified");
    step(1);
    chk(int'(sel_secondary), 1, "R9 over-current switches");
    pri_ocur_async = 0;
    step(3);
    send(0, 500);
    step(1);
    chk(int'(sel_secondary), 0, "R9 low sample resets count");
    pri_ocur_async = 1;
    step(3);
    send(0, 500); send(0, 500); send(0, 500);
    pri_ocur_async = 0;
    step(3);
    send(0, 500);
    pri_ocur_async = 1;
    step(3);
    send(0, 500); send(0, 500); send(0, 500);
    chk(int'(cfg_rdata[7]), 0, "R9 glitch broke the run");
    pri_ocur_async = 0;
    step(3);
    send(0, 500);
    cfg_wr(5, 32);

    // samples without valid are ignored
    @(negedge clk);
    pri_smp_volts = VW'(100);
    step(3);
    chk(int'(cfg_rdata[0]), 0, "R10 no-valid sample ignored");
    chk(int'(pri_led_green), 1, "R10 light unchanged without valid");

    // secondary masked, primary faults
    cfg_wr(4, 2);
    chk(int'(sec_led_green | sec_led_red), 0, "R4 masked lights off");
    send(0, 300);
    step(1);
    chk(int'(sel_secondary), 0, "R8 no switch to masked feed");
    chk(int'(pfail_irq), 1, "R8 irq with masked secondary");
    cfg_wr(4, 0);
    step(1);
    chk(int'(sel_secondary), 1, "R6 switch once unmasked");
    chk(int'(pfail_irq), 0, "R8 irq drops");
    send(1, 390);
    step(1);
    chk(int'(pfail_irq), 1, "R8 irq with secondary in UV");
    chk(int'(sel_secondary), 0, "R6 leave unhealthy secondary");
    send(1, 480); send(0, 480);
    step(1);
    chk(int'(pfail_irq), 0, "R8 irq clears on recovery");

    // primary masked at zero volts
    cfg_wr(4, 1);
    send(0, 0);
    step(1);
    chk(int'(cfg_rdata[0]), 0, "R4 masked feed raises no UV");
    chk(int'(pri_led_green | pri_led_red), 0, "R4 masked primary lights off");
    chk(int'(pfail_irq), 0, "R4 masked primary no irq");
    cfg_wr(4, 0);
    send(0, 480);

    // rewritten threshold
    cfg_wr(0, 450);
    rd(0, 450, "R3 UV set readback");
    send(0, 440);
    chk(int'(cfg_rdata[0]), 1, "R1 new UV set applies");
    send(0, 480);
    chk(int'(cfg_rdata[0]), 0, "R1 cleared above clear value");
    cfg_wr(0, 400);
    step(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule